// File: doc/BRIEF.md
# IDE Host Configuration Register Port

This block holds the byte-wide configuration registers of a dual-channel IDE host controller and makes them reachable through two I/O ports on a simple host bus. The host first writes a register number to the index port, then reads or writes the chosen register through the data port. The index is held between accesses, so repeated data accesses reach the same register until the host writes a new index. The stored fields drive the controller's timing and prefetch logic directly: per-drive prefetch disables, the secondary-channel enable, the command-block timing, the per-drive address-setup codes, the read/write pulse timings and the prefetch burst setting.

A strap input picks one of two base addresses for the port pair. The index port sits at the base and the data port sits four bytes above it. The read-only configuration register at index 0x50 reports the strap, the revision code, a device identifier and the channel interrupt. A revision code of 0 marks a part that cannot be used. A scratch register lets software confirm that the port answers before it relies on anything else.

Top module: `ide_cfg_regport`

## Requirements
- R1: With `baseSel`=0 the index port is at 0x178 and the data port at 0x17C. With `baseSel`=1 they are at 0x078 and 0x07C. Reads and writes at any other address get no response and change nothing.
- R2: A read strobe at either port raises `hostRdValid` for exactly one cycle, on the cycle after the strobe, with the data on `hostRdData`. Reading the index port returns the current index.
- R3: Index 0x50 is read-only. It reads {2'b00, baseSel, DEV_ID[1:0], irqPending, REV_CODE[1:0]}, bits 7:6 are always 0, and writes to it are ignored.
- R4: The control register at index 0x51 resets to 0xC0. Its bit 3 drives `secEnable`, bit 6 drives `pfDisable[0]` and bit 7 drives `pfDisable[1]`.
- R5: At index 0x57, bit 2 drives `pfDisable[2]`, bit 3 drives `pfDisable[3]`, and bits 7:6 drive `setupCode[5:4]`.
- R6: Reset gives 0x52=0x00, 0x53=0xC0, 0x54=0x00, 0x55=0xC0, 0x56=0x00, 0x57=0xCC, 0x58=0x00, 0x59=0x40 and 0x5B=0x00. After reset `pfDisable` is 4'hF and `secEnable` is 0. Outputs change only on a data-port write.
- R7: The scratch register at index 0x5B reads back the last byte written to it.
- R8: Indices outside 0x50..0x59 and 0x5B read 0x00, and writes to them are ignored. The index is held until the index port is written again.
- R9: `cmdTiming` follows 0x52 and `burstCfg` follows 0x59. `setupCode[1:0]` and `setupCode[3:2]` are bits 7:6 of 0x53 and 0x55. `rwTiming` bytes 0, 1 and 2 follow 0x54, 0x56 and 0x58.
- R10: When a write strobe and a read strobe arrive in the same cycle, the write takes effect and the read gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 10 | Host I/O address |
| hostWr | input | 1 | Write strobe, one cycle |
| hostRd | input | 1 | Read strobe, one cycle |
| hostWrData | input | 8 | Write byte |
| baseSel | input | 1 | Base strap: 0 selects 0x178, 1 selects 0x078 |
| irqPending | input | 1 | Channel 0/1 interrupt status, reported in index 0x50 |
| hostRdData | output | 8 | Read byte |
| hostRdValid | output | 1 | Read response strobe |
| secEnable | output | 1 | Secondary channel enable |
| pfDisable | output | 4 | Prefetch disable, one bit per drive 0..3 |
| revCode | output | 2 | Revision code |
| cmdTiming | output | 8 | Command-block timing byte |
| setupCode | output | 6 | Address-setup codes for drive 0, drive 1 and drives 2/3 |
| rwTiming | output | 24 | Read/write pulse timing bytes for drive 0, drive 1 and drives 2/3 |
| burstCfg | output | 8 | Prefetch burst setting |

## Verification
The assertions check on every cycle that read responses follow read strobes only at the two live addresses, that the index moves only on an index-port write, that no output moves without a data-port write, that a control-register write reaches the secondary enable and the drive 0/1 prefetch bits one cycle later, and that a configuration read reports the strap. The reset values, the exact bit positions of the drive 2/3 fields and the timing bytes, the scratch read-back, silent accesses to unimplemented indices and to the inactive base, and the write-wins rule for colliding strobes are shown only by the bench's scenarios, which compare read data and output fields against values fixed by the requirements.

// File: rtl/ide_cfg_regport_pkg.sv
package ide_cfg_regport_pkg;

  localparam int DATA_W   = 8;
  localparam int NREG     = 12;
  localparam logic [7:0] FIRST_IDX = 8'h50;

  localparam int OFS_CFG     = 0;
  localparam int OFS_CTRL    = 1;
  localparam int OFS_CMDTIM  = 2;
  localparam int OFS_SETUP0  = 3;
  localparam int OFS_RW0     = 4;
  localparam int OFS_SETUP1  = 5;
  localparam int OFS_RW1     = 6;
  localparam int OFS_SETUP23 = 7;
  localparam int OFS_RW23    = 8;
  localparam int OFS_BURST   = 9;
  localparam int OFS_HOLE    = 10;
  localparam int OFS_SCRATCH = 11;

  typedef struct packed {
    logic idxWr;
    logic dataWr;
    logic idxRd;
    logic dataRd;
  } portStrobe_t;

  function automatic logic [DATA_W-1:0] regResetVal(input int ofs);
    case (ofs)
      OFS_CTRL:    return 8'hC0;
      OFS_SETUP0:  return 8'hC0;
      OFS_SETUP1:  return 8'hC0;
      OFS_SETUP23: return 8'hCC;
      OFS_BURST:   return 8'h40;
      default:     return 8'h00;
    endcase
  endfunction

  function automatic logic regStored(input int ofs);
    return (ofs != OFS_CFG) && (ofs != OFS_HOLE);
  endfunction

endpackage

// File: rtl/ide_cfg_regport_ctrl.sv
module ide_cfg_regport_ctrl
  import ide_cfg_regport_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BASE_HI  = 'h178,
  parameter int BASE_LO  = 'h078,
  parameter int DATA_OFS = 4
) (
  input  logic              baseSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  output portStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] IDX_HI  = ADDR_W'(BASE_HI);
  localparam logic [ADDR_W-1:0] IDX_LO  = ADDR_W'(BASE_LO);
  localparam logic [ADDR_W-1:0] DATA_HI = ADDR_W'(BASE_HI + DATA_OFS);
  localparam logic [ADDR_W-1:0] DATA_LO = ADDR_W'(BASE_LO + DATA_OFS);

  logic hitIdx;
  logic hitData;

  always_comb begin
    hitIdx  = (hostAddr == (baseSel ? IDX_LO : IDX_HI));
    hitData = (hostAddr == (baseSel ? DATA_LO : DATA_HI));
    strobe.idxWr  = hostWr && hitIdx;
    strobe.dataWr = hostWr && hitData;
    // a write in the same cycle wins; the read is dropped
    strobe.idxRd  = hostRd && !hostWr && hitIdx;
    strobe.dataRd = hostRd && !hostWr && hitData;
  end

endmodule

// File: rtl/ide_cfg_regport_dp.sv
module ide_cfg_regport_dp
  import ide_cfg_regport_pkg::*;
#(
  parameter int REV_CODE = 2,
  parameter int DEV_ID   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              baseSel,
  input  logic              irqPending,
  output logic [DATA_W-1:0] rdByte,
  output logic              rdValid,
  output logic              secEnable,
  output logic [3:0]        pfDisable,
  output logic [7:0]        cmdTiming,
  output logic [5:0]        setupCode,
  output logic [23:0]       rwTiming,
  output logic [7:0]        burstCfg
);

  localparam int OFS_W = $clog2(NREG);
  localparam logic [1:0] REV_BITS = 2'(REV_CODE);
  localparam logic [1:0] DEV_BITS = 2'(DEV_ID);

  logic [DATA_W-1:0] curIdx;
  logic [DATA_W-1:0] bank [NREG];
  logic [DATA_W-1:0] idxOfs;
  logic              inRange;
  logic [OFS_W-1:0]  ofs;

  assign idxOfs  = curIdx - FIRST_IDX;
  assign inRange = (curIdx >= FIRST_IDX) && (idxOfs < DATA_W'(NREG));
  assign ofs     = idxOfs[OFS_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             curIdx <= '0;
    else if (strobe.idxWr) curIdx <= wrByte;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == OFS_CFG) begin : g_cfg
      assign bank[i] = {2'b00, baseSel, DEV_BITS, irqPending, REV_BITS};
    end else if (regStored(i)) begin : g_rw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          bank[i] <= regResetVal(i);
        else if (strobe.dataWr && inRange && (ofs == OFS_W'(i)))
          bank[i] <= wrByte;
      end
    end else begin : g_hole
      assign bank[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdByte  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.idxRd || strobe.dataRd;
      if (strobe.idxRd)
        rdByte <= curIdx;
      else if (strobe.dataRd)
        rdByte <= inRange ? bank[ofs] : '0;
    end
  end

  assign secEnable = bank[OFS_CTRL][3];
  assign pfDisable = {bank[OFS_SETUP23][3], bank[OFS_SETUP23][2],
                      bank[OFS_CTRL][7], bank[OFS_CTRL][6]};
  assign cmdTiming = bank[OFS_CMDTIM];
  assign setupCode = {bank[OFS_SETUP23][7:6], bank[OFS_SETUP1][7:6],
                      bank[OFS_SETUP0][7:6]};
  assign rwTiming  = {bank[OFS_RW23], bank[OFS_RW1], bank[OFS_RW0]};
  assign burstCfg  = bank[OFS_BURST];

endmodule

// File: rtl/ide_cfg_regport.sv
module ide_cfg_regport
  import ide_cfg_regport_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int BASE_HI  = 'h178,
  parameter int BASE_LO  = 'h078,
  parameter int DATA_OFS = 4,
  parameter int REV_CODE = 2,
  parameter int DEV_ID   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [7:0]        hostWrData,
  input  logic              baseSel,
  input  logic              irqPending,
  output logic [7:0]        hostRdData,
  output logic              hostRdValid,
  output logic              secEnable,
  output logic [3:0]        pfDisable,
  output logic [1:0]        revCode,
  output logic [7:0]        cmdTiming,
  output logic [5:0]        setupCode,
  output logic [23:0]       rwTiming,
  output logic [7:0]        burstCfg
);

  portStrobe_t strobe;

  ide_cfg_regport_ctrl #(
    .ADDR_W(ADDR_W), .BASE_HI(BASE_HI), .BASE_LO(BASE_LO), .DATA_OFS(DATA_OFS)
  ) u_ctrl (
    .baseSel(baseSel), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .strobe(strobe)
  );

  ide_cfg_regport_dp #(.REV_CODE(REV_CODE), .DEV_ID(DEV_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(hostWrData),
    .baseSel(baseSel), .irqPending(irqPending),
    .rdByte(hostRdData), .rdValid(hostRdValid),
    .secEnable(secEnable), .pfDisable(pfDisable), .cmdTiming(cmdTiming),
    .setupCode(setupCode), .rwTiming(rwTiming), .burstCfg(burstCfg)
  );

  assign revCode = 2'(REV_CODE);

endmodule

// File: rtl/ide_cfg_regport_chk.sv
module ide_cfg_regport_chk #(
  parameter int ADDR_W   = 10,
  parameter int BASE_HI  = 'h178,
  parameter int BASE_LO  = 'h078,
  parameter int DATA_OFS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostWr,
  input logic              hostRd,
  input logic [7:0]        hostWrData,
  input logic              baseSel,
  input logic [7:0]        hostRdData,
  input logic              hostRdValid,
  input logic [7:0]        curIdx,
  input logic              secEnable,
  input logic [3:0]        pfDisable,
  input logic [7:0]        cmdTiming,
  input logic [5:0]        setupCode,
  input logic [23:0]       rwTiming,
  input logic [7:0]        burstCfg
);

  logic [ADDR_W-1:0] idxA;
  logic [ADDR_W-1:0] dataA;
  logic              liveRd;
  logic              dataWrSeen;

  assign idxA       = baseSel ? ADDR_W'(BASE_LO) : ADDR_W'(BASE_HI);
  assign dataA      = idxA + ADDR_W'(DATA_OFS);
  assign liveRd     = hostRd && !hostWr && (hostAddr == idxA || hostAddr == dataA);
  assign dataWrSeen = hostWr && (hostAddr == dataA);

  a_r2_rd_valid: assert property (@(posedge clk) disable iff (!rstN)
    liveRd |=> hostRdValid);

  a_r1_no_stray_rd: assert property (@(posedge clk) disable iff (!rstN)
    !liveRd |=> !hostRdValid);

  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && hostAddr == idxA) |=> $stable(curIdx));

  a_r6_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrSeen |=> $stable({secEnable, pfDisable, cmdTiming, setupCode, rwTiming, burstCfg}));

  a_r4_ctrl_write: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrSeen && curIdx == 8'h51) |=>
      (secEnable == $past(hostWrData[3]) && pfDisable[1:0] == $past(hostWrData[7:6])));

  a_r3_cfg_strap: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostWr && hostAddr == dataA && curIdx == 8'h50) |=>
      (hostRdData[5] == $past(baseSel) && hostRdData[7:6] == 2'b00));

endmodule

bind ide_cfg_regport ide_cfg_regport_chk #(
  .ADDR_W(ADDR_W), .BASE_HI(BASE_HI), .BASE_LO(BASE_LO), .DATA_OFS(DATA_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
  .hostWrData(hostWrData), .baseSel(baseSel), .hostRdData(hostRdData),
  .hostRdValid(hostRdValid), .curIdx(u_dp.curIdx), .secEnable(secEnable),
  .pfDisable(pfDisable), .cmdTiming(cmdTiming), .setupCode(setupCode),
  .rwTiming(rwTiming), .burstCfg(burstCfg)
);

// File: tb/ide_cfg_regport_bench.sv
module ide_cfg_regport_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  hostAddr = '0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic        baseSel = 1'b0;
  logic        irqPending = 1'b0;
  logic [7:0]  hostRdData;
  logic        hostRdValid;
  logic        secEnable;
  logic [3:0]  pfDisable;
  logic [1:0]  revCode;
  logic [7:0]  cmdTiming;
  logic [5:0]  setupCode;
  logic [23:0] rwTiming;
  logic [7:0]  burstCfg;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] expByte [$];
  string      expTag [$];

  always #10 clk = ~clk;

  ide_cfg_regport u_ide_cfg_regport (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWrData(hostWrData), .baseSel(baseSel), .irqPending(irqPending),
    .hostRdData(hostRdData), .hostRdValid(hostRdValid), .secEnable(secEnable),
    .pfDisable(pfDisable), .revCode(revCode), .cmdTiming(cmdTiming),
    .setupCode(setupCode), .rwTiming(rwTiming), .burstCfg(burstCfg)
  );

  function automatic logic [9:0] idxAddr();
    return baseSel ? 10'h078 : 10'h178;
  endfunction

  function automatic logic [9:0] dataAddr();
    return idxAddr() + 10'd4;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read response
  always @(negedge clk) begin
    if (rstN && hostRdValid) begin
      if (expByte.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R1 unexpected response actual=%0h expected=none", hostRdData);
      end else begin
        automatic logic [7:0] e = expByte.pop_front();
        automatic string t = expTag.pop_front();
        check(t, 32'(hostRdData), 32'(e));
      end
    end
  end

  task automatic busWr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic busRd(input logic [9:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    expByte.push_back(e); expTag.push_back(tag);
    hostAddr = a; hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic busRdNone(input logic [9:0] a, input string tag);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    check(tag, 32'(hostRdValid), 32'd0);
  endtask

  task automatic regWr(input logic [7:0] idx, input logic [7:0] d);
    busWr(idxAddr(), idx);
    busWr(dataAddr(), d);
  endtask

  task automatic regRd(input logic [7:0] idx, input logic [7:0] e, input string tag);
    busWr(idxAddr(), idx);
    busRd(dataAddr(), e, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6 reset state at the outputs
    check("R6 pfDisable", 32'(pfDisable), 32'hF);
    check("R6 secEnable", 32'(secEnable), 32'd0);
    check("R6 cmdTiming", 32'(cmdTiming), 32'h00);
    check("R6 setupCode", 32'(setupCode), 32'h3F);
    check("R6 rwTiming", rwTiming, 32'h0);
    check("R6 burstCfg", 32'(burstCfg), 32'h40);
    check("R6 rdValid", 32'(hostRdValid), 32'd0);
    check("R3 revCode", 32'(revCode), 32'd2);

    // R6 reset values read through the port
    regRd(8'h51, 8'hC0, "R6 ctrl");
    regRd(8'h52, 8'h00, "R6 cmd");
    regRd(8'h53, 8'hC0, "R6 setup0");
    regRd(8'h55, 8'hC0, "R6 setup1");
    regRd(8'h57, 8'hCC, "R6 setup23");
    regRd(8'h59, 8'h40, "R6 burst");
    regRd(8'h5B, 8'h00, "R6 scratch");

    // R3 configuration register
    regRd(8'h50, 8'h02, "R3 cfg strap0");
    irqPending = 1'b1;
    regRd(8'h50, 8'h06, "R3 cfg irq");
    regWr(8'h50, 8'hFF);
    busRd(dataAddr(), 8'h06, "R3 cfg write ignored");

    // R4 control fields
    regWr(8'h51, 8'h08);
    check("R4 secEnable", 32'(secEnable), 32'd1);
    check("R4 pfDisable", 32'(pfDisable), 32'hC);
    regWr(8'h51, 8'h40);
    check("R4 secEnable off", 32'(secEnable), 32'd0);
    check("R4 pfDisable d0", 32'(pfDisable), 32'hD);

    // R5 secondary drive fields
    regWr(8'h57, 8'h44);
    check("R5 pfDisable", 32'(pfDisable), 32'h5);
    check("R5 setupCode23", 32'(setupCode[5:4]), 32'h1);

    // R9 timing outputs
    regWr(8'h53, 8'h80);
    check("R9 setupCode0", 32'(setupCode[1:0]), 32'h2);
    regWr(8'h54, 8'h3A);
    regWr(8'h56, 8'h5C);
    regWr(8'h58, 8'h21);
    check("R9 rwTiming", rwTiming, 32'h215C3A);
    regWr(8'h52, 8'h05);
    check("R9 cmdTiming", 32'(cmdTiming), 32'h05);
    regWr(8'h59, 8'h00);
    check("R9 burstCfg", 32'(burstCfg), 32'h00);

    // R7 scratch
    regWr(8'h5B, 8'hBD);
    busRd(dataAddr(), 8'hBD, "R7 scratch BD");
    regWr(8'h5B, 8'h00);
    busRd(dataAddr(), 8'h00, "R7 scratch 00");

    // R8 unimplemented indices and held index
    regWr(8'h40, 8'h77);
    busRd(dataAddr(), 8'h00, "R8 idx40");
    regWr(8'h5A, 8'h77);
    busRd(dataAddr(), 8'h00, "R8 idx5A");
    regWr(8'hFF, 8'h77);
    busRd(dataAddr(), 8'h00, "R8 idxFF");
    check("R8 outputs untouched", {secEnable, pfDisable, burstCfg}, 32'h0500);
    busWr(idxAddr(), 8'h5B);
    busWr(dataAddr(), 8'h11);
    busRd(dataAddr(), 8'h11, "R8 held index 1");
    busRd(dataAddr(), 8'h11, "R8 held index 2");
    busRd(idxAddr(), 8'h5B, "R2 index read");

    // R1 inactive base ignored
    busRdNone(10'h078, "R1 other idx");
    busRdNone(10'h07C, "R1 other data");
    busWr(idxAddr(), 8'h51);
    busWr(10'h07C, 8'hFF);
    check("R1 write ignored", {secEnable, pfDisable}, 32'h05);
    busRdNone(10'h100, "R1 stray addr");

    // R1 strap change moves the port
    baseSel = 1'b1;
    regRd(8'h50, 8'h26, "R1 cfg via low base");
    busRdNone(10'h17C, "R1 high base silent");

    // R10 collision: write wins, no response
    busWr(idxAddr(), 8'h5B);
    @(negedge clk);
    hostAddr = dataAddr(); hostWrData = 8'h3C; hostWr = 1'b1; hostRd = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
    check("R10 no response", 32'(hostRdValid), 32'd0);
    busRd(dataAddr(), 8'h3C, "R10 write taken");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 32'(expByte.size()), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule